// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block owns the clock-enable line of a DDR SDRAM and walks the device into and out of its low-power state. A power-down request from the controller is honoured only when no access is in flight; the request is otherwise held pending until the busy flag clears. On entry the block records whether every bank was idle, and reports the residency as either the precharge kind (all banks closed) or the active kind (a row still open).

While the clock enable is low, the command scheduler is told that nothing may be issued, so it sends only NOPs. Leaving power-down raises the clock enable and blocks commands for one more cycle. A residency timer forces an exit before the refresh interval, less a configurable safety margin, runs out. After a forced exit the block does not re-enter until the request has been seen low. If the DLL-off option was set at entry, the block pulses a DLL re-enable request on exit. It then keeps READs blocked for a parameterised settle window, while other commands are allowed again.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: During and after reset, with no request, `cke`, `cmd_allowed` and `read_allowed` are 1, and `in_pd`, `pd_is_active` and `dll_enable_req` are 0.
- R2: From the powered-up idle state, `pd_req`=1 with `busy`=0 drives `cke` low (and `in_pd` high) on the next cycle. While `busy`=1 or `pd_req`=0, `cke` stays high, and a request held through `busy` is taken the cycle after `busy` drops.
- R3: Whenever `cke` is 0, `cmd_allowed` and `read_allowed` are 0.
- R4: `pd_is_active` is 1 if `banks_idle` was 0 in the cycle the entry was taken, and 0 if it was 1. It stays constant while `cke` is low and holds its value until the next entry.
- R5: `cke` stays low for at least two cycles. Once past the first low cycle, `pd_req`=0 raises `cke` on the next cycle, and in that exit cycle `cmd_allowed` is 0. With the DLL-off option clear, `cmd_allowed` and `read_allowed` return to 1 one cycle later.
- R6: `cke` is never low for more than PD_LIMIT_CYCLES minus PD_MARGIN_CYCLES consecutive cycles. With `pd_req` held high, it is low for exactly that many cycles and then forced high.
- R7: After a forced exit, `cke` stays high while `pd_req` remains 1. Once `pd_req` has been sampled 0, a new request enters again.
- R8: If `dll_off_en` was 1 in the entry cycle, `dll_enable_req` is 1 for exactly the exit cycle. After that, `cmd_allowed` is 1 but `read_allowed` stays 0 for DLL_WAIT_CYCLES more cycles.
- R9: `read_allowed` is never 1 while `cmd_allowed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Request to enter and stay in power-down |
| busy | input | 1 | An access is in progress; entry is deferred |
| banks_idle | input | 1 | All banks are precharged |
| dll_off_en | input | 1 | Power-down is taken with the DLL switched off |
| cke | output | 1 | Clock enable to the SDRAM |
| cmd_allowed | output | 1 | Scheduler may issue non-NOP commands |
| read_allowed | output | 1 | Scheduler may issue READ commands |
| in_pd | output | 1 | Clock enable is currently held low |
| pd_is_active | output | 1 | 1: active power-down, 0: precharge power-down |
| dll_enable_req | output | 1 | One-cycle request to re-enable the DLL |

## Verification
The properties assume that `busy` truly reflects outstanding accesses and that the scheduler obeys `cmd_allowed`. They also take `banks_idle` and `dll_off_en` to matter only in the cycle where the entry is taken. The stimulus changes inputs only between clock edges and keeps `busy` low whenever it expects an entry. It deliberately toggles `banks_idle`, `busy` and `dll_off_en` while `cke` is low, to show that those changes have no effect there. The forced-exit case holds `pd_req` high across the whole residency and beyond, so that both the residency limit and the re-arm rule are exercised.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [2:0] {
      ST_UP      = 3'd0,   // clock enable high, normal operation
      ST_DROP    = 3'd1,   // first cycle with clock enable low
      ST_SLEEP   = 3'd2,   // residency
      ST_WAKE    = 3'd3,   // clock enable high again, commands held off
      ST_SETTLE  = 3'd4    // DLL settle window, reads held off
   } pdc_state_e;

endpackage

// File: rtl/pdc_cycle_timer.sv
module pdc_cycle_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pdc_cycle_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
   import pdc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pd_req,
   input  logic       busy,
   input  logic       banks_idle,
   input  logic       dll_off,
   input  logic       limit_hit,
   input  logic       settle_done,
   output pdc_state_e state,
   output logic       kind_active,
   output logic       dll_was_off
);
   pdc_state_e state_nx;
   logic       hold_off;   // set by a forced exit, cleared when the request drops
   logic       take;

   assign take = (state == ST_UP) && pd_req && !busy && !hold_off;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_UP:     if (take) state_nx = ST_DROP;
         ST_DROP:   state_nx = ST_SLEEP;
         ST_SLEEP:  if (!pd_req || limit_hit) state_nx = ST_WAKE;
         ST_WAKE:   state_nx = dll_was_off ? ST_SETTLE : ST_UP;
         ST_SETTLE: if (settle_done) state_nx = ST_UP;
         default:   state_nx = ST_UP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_UP;
         kind_active <= 1'b0;
         dll_was_off <= 1'b0;
         hold_off    <= 1'b0;
      end else begin
         state <= state_nx;
         if (take) begin
            kind_active <= !banks_idle;
            dll_was_off <= dll_off;
         end
         if (state == ST_SLEEP && pd_req && limit_hit) hold_off <= 1'b1;
         else if (!pd_req)                             hold_off <= 1'b0;
      end
   end

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
   import pdc_pkg::*;
#(
   parameter int PD_LIMIT_CYCLES  = 6_400_000,
   parameter int PD_MARGIN_CYCLES = 6_400,
   parameter int DLL_WAIT_CYCLES  = 200,
   parameter bit ALLOW_DLL_OFF    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic busy,
   input  logic banks_idle,
   input  logic dll_off_en,
   output logic cke,
   output logic cmd_allowed,
   output logic read_allowed,
   output logic in_pd,
   output logic pd_is_active,
   output logic dll_enable_req
);
   localparam int PD_MAX = PD_LIMIT_CYCLES - PD_MARGIN_CYCLES;

   if (PD_MARGIN_CYCLES < 0) begin : g_bad_margin
      $error("sdram_pd_ctrl: PD_MARGIN_CYCLES must not be negative");
   end
   if (PD_MAX < 2) begin : g_bad_limit
      $error("sdram_pd_ctrl: residency limit minus margin must be at least 2");
   end
   if (ALLOW_DLL_OFF && DLL_WAIT_CYCLES < 1) begin : g_bad_wait
      $error("sdram_pd_ctrl: DLL_WAIT_CYCLES must be at least 1");
   end

   pdc_state_e state;
   logic       limit_hit;
   logic       settle_done;
   logic       dll_off_eff;
   logic       dll_was_off;

   pdc_cycle_timer #(.LIMIT(PD_MAX)) u_res_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_DROP || state == ST_SLEEP),
      .done (limit_hit)
   );

   if (ALLOW_DLL_OFF) begin : g_dll
      assign dll_off_eff = dll_off_en;
      pdc_cycle_timer #(.LIMIT(DLL_WAIT_CYCLES)) u_settle_timer (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (state == ST_SETTLE),
         .done (settle_done)
      );
   end else begin : g_no_dll
      logic unused_dll_off;
      assign unused_dll_off = dll_off_en;
      assign dll_off_eff    = 1'b0;
      assign settle_done    = 1'b1;
   end

   pdc_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pd_req     (pd_req),
      .busy       (busy),
      .banks_idle (banks_idle),
      .dll_off    (dll_off_eff),
      .limit_hit  (limit_hit),
      .settle_done(settle_done),
      .state      (state),
      .kind_active(pd_is_active),
      .dll_was_off(dll_was_off)
   );

   always_comb begin
      in_pd          = (state == ST_DROP) || (state == ST_SLEEP);
      cke            = !in_pd;
      cmd_allowed    = (state == ST_UP) || (state == ST_SETTLE);
      read_allowed   = (state == ST_UP);
      dll_enable_req = (state == ST_WAKE) && dll_was_off;
   end

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
   parameter int PD_MAX   = 2,
   parameter int DLL_WAIT = 1
) (
   input logic clk,
   input logic rst_n,
   input logic pd_req,
   input logic busy,
   input logic cke,
   input logic cmd_allowed,
   input logic read_allowed,
   input logic pd_is_active,
   input logic dll_enable_req
);
   localparam int LW = $clog2(PD_MAX + 2);
   localparam int DW = $clog2(DLL_WAIT + 2);

   logic [LW-1:0] low_run;   // consecutive low cycles before the current one
   logic [DW-1:0] win;       // read hold-off cycles still owed
   logic          blk;       // a forced exit happened and the request has not dropped

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_run <= '0;
         win     <= '0;
         blk     <= 1'b0;
      end else begin
         if (cke)                               low_run <= '0;
         else if (low_run != LW'(PD_MAX + 1))   low_run <= low_run + 1'b1;

         if (dll_enable_req)  win <= DW'(DLL_WAIT);
         else if (win != '0)  win <= win - 1'b1;

         if (!cke && pd_req && low_run == LW'(PD_MAX - 1)) blk <= 1'b1;
         else if (!pd_req)                                 blk <= 1'b0;
      end
   end

   assert_cmd_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (!cmd_allowed && !read_allowed));

   assert_read_needs_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      read_allowed |-> cmd_allowed);

   assert_busy_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && busy) |=> cke);

   assert_no_req_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !pd_req) |=> cke);

   assert_kind_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> (cke || $stable(pd_is_active)));

   assert_exit_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && low_run != '0 && !pd_req) |=> (cke && !cmd_allowed));

   assert_residency_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (low_run < LW'(PD_MAX)));

   assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk && cke) |=> cke);

   assert_dll_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dll_enable_req |-> (cke && !cmd_allowed));

   assert_dll_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dll_enable_req |=> !dll_enable_req);

   assert_read_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      read_allowed |-> (win == '0));

   logic unused_busy_only_in_props;
   assign unused_busy_only_in_props = busy;

endmodule

bind sdram_pd_ctrl pdc_checker #(
   .PD_MAX  (PD_LIMIT_CYCLES - PD_MARGIN_CYCLES),
   .DLL_WAIT(DLL_WAIT_CYCLES)
) u_pdc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .pd_req        (pd_req),
   .busy          (busy),
   .cke           (cke),
   .cmd_allowed   (cmd_allowed),
   .read_allowed  (read_allowed),
   .pd_is_active  (pd_is_active),
   .dll_enable_req(dll_enable_req)
);

// File: tb/sdram_pd_ctrl_tb.sv
module sdram_pd_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 48;
   localparam int MARGIN     = 8;
   localparam int PD_MAX     = LIMIT - MARGIN;
   localparam int DLL_WAIT   = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_req = 1'b0, busy = 1'b0, banks_idle = 1'b1, dll_off_en = 1'b0;
   logic cke, cmd_allowed, read_allowed, in_pd, pd_is_active, dll_enable_req;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_pd_ctrl #(
      .PD_LIMIT_CYCLES (LIMIT),
      .PD_MARGIN_CYCLES(MARGIN),
      .DLL_WAIT_CYCLES (DLL_WAIT),
      .ALLOW_DLL_OFF   (1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .busy(busy),
      .banks_idle(banks_idle), .dll_off_en(dll_off_en), .cke(cke),
      .cmd_allowed(cmd_allowed), .read_allowed(read_allowed), .in_pd(in_pd),
      .pd_is_active(pd_is_active), .dll_enable_req(dll_enable_req)
   );

   // inputs {req,busy,idle,dll} ; expected {cke,cmd,rd,in_pd,kind,dll_req}
   localparam logic [9:0] VEC [12] = '{
      {4'b0010, 6'b111000},   // R1 idle, no request
      {4'b1110, 6'b111000},   // R2 request deferred by busy
      {4'b1110, 6'b111000},   // R2 still deferred
      {4'b1000, 6'b000110},   // R2/R4 entry with a row open -> active kind
      {4'b1110, 6'b000110},   // R3/R4 inputs ignored while low
      {4'b1010, 6'b000110},   // R3 residency
      {4'b0010, 6'b100010},   // R5 exit cycle, commands blocked
      {4'b0010, 6'b111010},   // R5 commands back, kind held
      {4'b1010, 6'b000100},   // R4 entry with banks idle -> precharge kind
      {4'b1010, 6'b000100},   // R3 residency
      {4'b0010, 6'b100000},   // R5 exit cycle
      {4'b0010, 6'b111000}    // R5 back to normal
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [5:0] outs();
      return {cke, cmd_allowed, read_allowed, in_pd, pd_is_active, dll_enable_req};
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n;
      bit bad;

      // R1 reset state
      repeat (3) step();
      check(outs() == 6'b111000, "R1 during reset", outs(), 6'b111000);
      rst_n = 1'b1;
      step();
      check(outs() == 6'b111000, "R1 after reset", outs(), 6'b111000);

      // table walk
      foreach (VEC[i]) begin
         {pd_req, busy, banks_idle, dll_off_en} = VEC[i][9:6];
         step();
         check(outs() == VEC[i][5:0], $sformatf("R2/R3/R4/R5 row %0d", i),
               outs(), VEC[i][5:0]);
      end

      // R6 forced exit with request held
      pd_req = 1'b1; busy = 1'b0; banks_idle = 1'b1; dll_off_en = 1'b0;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         step();
         if (!cke) n++;
         else if (n > 0) break;
      end
      check(n == PD_MAX, "R6 low cycles under held request", n, PD_MAX);
      check(cke && !cmd_allowed, "R5 forced exit cycle blocks commands",
            cmd_allowed, 0);

      // R7 no re-entry while request stays high
      bad = 1'b0;
      for (int k = 0; k < 10; k++) begin
         step();
         if (!cke) bad = 1'b1;
      end
      check(!bad, "R7 held request after forced exit", bad, 0);
      pd_req = 1'b0;
      step();
      pd_req = 1'b1;
      step();
      check(!cke && in_pd, "R7 re-entry after request dropped", cke, 0);
      pd_req = 1'b0;
      step();
      check(!cke, "R5 minimum two low cycles", cke, 0);
      step();
      step();
      check(cmd_allowed && read_allowed, "R5 return after short residency",
            {cmd_allowed, read_allowed}, 3);

      // R8 DLL-off residency
      dll_off_en = 1'b1; banks_idle = 1'b0; pd_req = 1'b1;
      step();
      check(!cke && pd_is_active, "R4 active kind with DLL off", pd_is_active, 1);
      dll_off_en = 1'b0; banks_idle = 1'b1;
      step();
      pd_req = 1'b0;
      step();
      check(cke && dll_enable_req && !cmd_allowed, "R8 exit pulses DLL enable",
            dll_enable_req, 1);
      step();
      check(!dll_enable_req && cmd_allowed && !read_allowed,
            "R8 settle window commands open reads blocked",
            {dll_enable_req, cmd_allowed, read_allowed}, 3'b010);
      n = 1;
      bad = 1'b0;
      for (int k = 0; k < 400; k++) begin
         step();
         if (read_allowed) break;
         n++;
         if (!cmd_allowed || dll_enable_req) bad = 1'b1;
      end
      check(n == DLL_WAIT, "R8 read hold-off length", n, DLL_WAIT);
      check(!bad, "R9 commands stay open during hold-off", bad, 0);
      check(read_allowed && cmd_allowed, "R9 reads reopen with commands",
            {cmd_allowed, read_allowed}, 3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule